// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register read and write transactions to an external PHY over a two-wire serial management link. It has a clock output and a data line that is shared in both directions. The host presents a PHY address, a register address, write data and a read/write select, and pulses a start strobe. The block then runs the whole frame by itself. It raises a one-cycle done pulse when the frame is finished. Read results appear on a data output, together with a flag that shows whether any PHY answered.

The management clock is made from the system clock by a programmable divider. Each management clock cycle is one low half followed by one high half. The master changes the data line only at the start of a low half. It samples the incoming line at the end of a low half, just before the clock rises. The block drives an output-enable signal that steers an external tri-state pad. The incoming data passes through a synchronizer before it is used.

A read that gets no acknowledge still runs its full length. This keeps every PHY on the link in step with the frame. Both reads and writes end with the clock low and the data line released.

Top module: `mgmt_serial_master`

## Requirements
- R1: Every frame starts with a preamble of PRE_LEN (32) clock cycles. During the preamble the data line is driven high and the output enable is asserted.
- R2: After the preamble, 14 header bits are sent MSB first: start pattern 2'b01, operation 2'b10 for read or 2'b01 for write, the 5-bit PHY address, then the 5-bit register address.
- R3: A write continues with turnaround 2'b10, then 16 data bits MSB first, then one idle cycle with the line driven high. After that the output enable drops. A write frame is 65 clock cycles, all of them driven.
- R4: A read follows the register address with one idle cycle driven low. It then releases the line: the output enable is low from the acknowledge cycle onward, so 47 cycles are driven. The line is sampled once in the acknowledge cycle, and a low value means a PHY responded.
- R5: On an acknowledged read, 16 data bits are captured MSB first. Each bit is sampled at the end of the clock-low half. The result is presented on rdata_o with nack_o low at the done pulse.
- R6: If the acknowledge sample is high, the master still clocks 16 further cycles but captures nothing. It reports nack_o high with rdata_o zero, and the frame still lasts 65 cycles.
- R7: Every read ends with one extra trailing clock cycle, for 65 cycles in total. When done is pulsed, the clock is low and the output enable is low.
- R8: The data output changes only while the management clock is low.
- R9: Each clock half lasts DIV_HALF system cycles, so the rising edges within a frame are 2*DIV_HALF system cycles apart.
- R10: busy_o rises in the cycle after an accepted start and falls together with a single-cycle done_o pulse. A start strobe seen while busy is ignored.
- R11: After reset: mdc_o low, mdio_oe_o low, busy_o low, done_o low, rdata_o zero and nack_o low.
- R12: A write completes with nack_o low and leaves rdata_o holding the previous read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when not busy |
| write_i | input | 1 | 1 = write frame, 0 = read frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| rdata_o | output | DATA_W | Last read result (zero on failure) |
| nack_o | output | 1 | Last frame had no PHY acknowledge |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with DIV_HALF = 3 and SYNC_STAGES = 2, and with the default 32-cycle preamble and 16-bit data. This is the smallest divider that still exceeds the synchronizer latency. As a result, a PHY-model bit driven at a falling edge reaches the sampling point with only one system cycle of margin, which exposes any extra latency in the capture path. With the short, odd divider, a five-frame sequence takes a few thousand cycles. That is enough to cover the following cases:
- an acknowledged read after a write;
- a write that must keep the earlier read result;
- a failed read whose PHY model keeps driving a data pattern that must not be captured;
- a start strobe given in the middle of a frame.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam int PHY_AW = 5;
  localparam int REG_AW = 5;
  localparam int TA_W   = 2;
  localparam int HDR_W  = 4 + PHY_AW + REG_AW;

  localparam logic [1:0] SOF_PAT = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_SHIFT,
    SQ_WIDLE,
    SQ_RIDLE,
    SQ_ACK,
    SQ_RDATA,
    SQ_TRAIL
  } seq_state_e;

endpackage

// File: rtl/mgmt_tick_gen.sv
module mgmt_tick_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);

  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    if (!run_i || tick_o) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/mgmt_in_sync.sv
module mgmt_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  if (STAGES <= 1) begin : g_single
    logic s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= RST_VAL;
      end else begin
        s_q <= din;
      end
    end
    assign dout = s_q;
  end else begin : g_chain
    logic [STAGES-1:0] s_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= {STAGES{RST_VAL}};
      end else begin
        s_q <= {s_q[STAGES-2:0], din};
      end
    end
    assign dout = s_q[STAGES-1];
  end

endmodule

// File: rtl/mgmt_frame_seq.sv
module mgmt_frame_seq
  import mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nack_o
);

  localparam int TX_W    = HDR_W + TA_W + DATA_W;
  localparam int MAX_CNT = (PRE_LEN > TX_W) ? PRE_LEN : TX_W;
  localparam int CNT_W   = $clog2(MAX_CNT) + 1;

  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(TX_W - 1);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              mdc_q, mdc_d;
  logic              dout_q, dout_d;
  logic              oe_q, oe_d;
  logic [TX_W-1:0]   tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              wr_q, wr_d;
  logic              fail_q, fail_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              nack_q, nack_d;
  logic              done_q, done_d;

  logic active;
  logic rise_evt;
  logic fall_evt;
  logic cnt_zero;

  assign active   = (state_q != SQ_IDLE);
  assign rise_evt = active && tick_i && !mdc_q;
  assign fall_evt = active && tick_i && mdc_q;
  assign cnt_zero = (cnt_q == '0);

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mdc_d   = mdc_q;
    dout_d  = dout_q;
    oe_d    = oe_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    wr_d    = wr_q;
    fail_d  = fail_q;
    rdata_d = rdata_q;
    nack_d  = nack_q;
    done_d  = 1'b0;

    if (!active) begin
      mdc_d = 1'b0;
      if (start_i) begin
        wr_d    = write_i;
        tx_d    = {SOF_PAT, (write_i ? OP_WR : OP_RD), phy_addr_i,
                   reg_addr_i, TA_WR, wdata_i};
        rx_d    = '0;
        fail_d  = 1'b0;
        state_d = SQ_PRE;
        cnt_d   = PRE_LAST;
        dout_d  = 1'b1;
        oe_d    = 1'b1;
      end
    end else if (rise_evt) begin
      // end of the low half: sample, then raise the clock
      mdc_d = 1'b1;
      if (state_q == SQ_ACK) begin
        fail_d = mdio_i;
      end
      if ((state_q == SQ_RDATA) && !fail_q) begin
        rx_d = {rx_q[DATA_W-2:0], mdio_i};
      end
    end else if (fall_evt) begin
      // end of the high half: close this cycle, set up the next one
      mdc_d = 1'b0;
      unique case (state_q)
        SQ_PRE: begin
          if (cnt_zero) begin
            state_d = SQ_SHIFT;
            cnt_d   = wr_q ? TX_LAST : HDR_LAST;
            dout_d  = tx_q[TX_W-1];
            tx_d    = {tx_q[TX_W-2:0], 1'b0};
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        SQ_SHIFT: begin
          if (cnt_zero) begin
            state_d = wr_q ? SQ_WIDLE : SQ_RIDLE;
            dout_d  = wr_q;
          end else begin
            cnt_d  = cnt_q - CNT_W'(1);
            dout_d = tx_q[TX_W-1];
            tx_d   = {tx_q[TX_W-2:0], 1'b0};
          end
        end
        SQ_WIDLE: begin
          state_d = SQ_IDLE;
          oe_d    = 1'b0;
          nack_d  = 1'b0;
          done_d  = 1'b1;
        end
        SQ_RIDLE: begin
          state_d = SQ_ACK;
          oe_d    = 1'b0;
          dout_d  = 1'b1;
        end
        SQ_ACK: begin
          state_d = SQ_RDATA;
          cnt_d   = DATA_LAST;
        end
        SQ_RDATA: begin
          if (cnt_zero) begin
            state_d = SQ_TRAIL;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
        SQ_TRAIL: begin
          state_d = SQ_IDLE;
          nack_d  = fail_q;
          rdata_d = fail_q ? '0 : rx_q;
          done_d  = 1'b1;
        end
        default: begin
          state_d = SQ_IDLE;
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      mdc_q   <= 1'b0;
      dout_q  <= 1'b1;
      oe_q    <= 1'b0;
      tx_q    <= '0;
      rx_q    <= '0;
      wr_q    <= 1'b0;
      fail_q  <= 1'b0;
      rdata_q <= '0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mdc_q   <= mdc_d;
      dout_q  <= dout_d;
      oe_q    <= oe_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      wr_q    <= wr_d;
      fail_q  <= fail_d;
      rdata_q <= rdata_d;
      nack_q  <= nack_d;
      done_q  <= done_d;
    end
  end

  assign run_o     = active;
  assign busy_o    = active;
  assign mdc_o     = mdc_q;
  assign mdio_o    = dout_q;
  assign mdio_oe_o = oe_q;
  assign done_o    = done_q;
  assign rdata_o   = rdata_q;
  assign nack_o    = nack_q;

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int DIV_HALF    = 4,
  parameter int PRE_LEN     = 32,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              nack_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       run;
  logic       tick;
  logic       mdio_sync;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  mgmt_tick_gen #(
    .DIV_HALF (DIV_HALF)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (run),
    .tick_o (tick)
  );

  mgmt_in_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .din   (mdio_i),
    .dout  (mdio_sync)
  );

  mgmt_frame_seq #(
    .PRE_LEN (PRE_LEN),
    .DATA_W  (DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (tick),
    .start_i    (start_i),
    .write_i    (write_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .mdio_i     (mdio_sync),
    .run_o      (run),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .nack_o     (nack_o)
  );

endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              nack_o,
  input logic [DATA_W-1:0] rdata_o
);

  // R8
  data_low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R7
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R6
  nack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_o |-> (rdata_o == '0));

endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .nack_o    (nack_o),
  .rdata_o   (rdata_o)
);

// File: tb/tb_mgmt_serial_master.sv
`timescale 1ns/1ps
module tb_mgmt_serial_master;

  localparam int DIV   = 3;
  localparam int DW    = 16;

  typedef struct {
    logic [127:0] bits;
    int           len;
    logic [15:0]  rd;
    logic         nack;
    logic         wr;
    logic         resp;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        write_i;
  logic [4:0]  phy_addr_i;
  logic [4:0]  reg_addr_i;
  logic [15:0] wdata_i;
  logic        busy_o, done_o, nack_o, mdc_o, mdio_o, mdio_oe_o;
  logic [15:0] rdata_o;
  logic        mdio_i;

  int n_chk = 0;
  int n_err = 0;
  int n_done = 0;
  int r8_bad = 0;
  exp_t sb_q[$];

  logic [127:0] cap;
  int n_oe, n_rise, per_bad, last_rise, cyc;
  logic prev_dout;

  bit        cur_rd;
  bit        phy_resp;
  logic [15:0] phy_data;
  logic [15:0] last_rd;

  mgmt_serial_master #(
    .DIV_HALF    (DIV),
    .PRE_LEN     (32),
    .DATA_W      (DW),
    .SYNC_STAGES (2)
  ) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .write_i    (write_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .nack_o     (nack_o),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .mdio_i     (mdio_i)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cycle counter and frame capture at management clock rising edges
  always @(posedge clk) cyc++;

  always @(posedge mdc_o) begin
    if (rst_n) begin
      n_rise++;
      if (n_rise > 1 && (cyc - last_rise) != 2 * DIV) per_bad++;
      last_rise = cyc;
      if (mdio_oe_o) begin
        cap = {cap[126:0], mdio_o};
        n_oe++;
      end
    end
  end

  // PHY model: answers read frames after the master releases the line
  always @(negedge mdio_oe_o) begin
    if (rst_n && cur_rd) begin
      mdio_i = phy_resp ? 1'b0 : 1'b1;
      for (int i = 15; i >= 0; i--) begin
        @(negedge mdc_o);
        mdio_i = phy_data[i];
      end
      @(negedge mdc_o);
      mdio_i = 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mdio_o !== prev_dout && mdc_o) r8_bad++;
      prev_dout = mdio_o;
      if (done_o) begin
        n_done++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R10", "done without pending frame", 128'd1, 128'd0);
        end else begin
          exp_t e;
          string tl;
          logic [127:0] m;
          e  = sb_q.pop_front();
          tl = e.wr ? "R3" : "R4";
          chk(((cap >> (e.len - 32)) & 128'hFFFF_FFFF) ==
              ((e.bits >> (e.len - 32)) & 128'hFFFF_FFFF),
              "R1", "preamble bits", cap >> (e.len - 32), e.bits >> (e.len - 32));
          chk(((cap >> (e.len - 46)) & 128'h3FFF) ==
              ((e.bits >> (e.len - 46)) & 128'h3FFF),
              "R2", "header bits", (cap >> (e.len - 46)) & 128'h3FFF,
              (e.bits >> (e.len - 46)) & 128'h3FFF);
          m = (128'd1 << (e.len - 46)) - 128'd1;
          chk((cap & m) == (e.bits & m), tl, "tail bits", cap & m, e.bits & m);
          chk(n_oe == e.len, tl, "driven cycles", 128'(n_oe), 128'(e.len));
          chk(n_rise == 65, e.wr ? "R3" : (e.resp ? "R7" : "R6"),
              "total clock cycles", 128'(n_rise), 128'd65);
          chk(per_bad == 0, "R9", "clock period violations", 128'(per_bad), 128'd0);
          chk(!mdc_o && !mdio_oe_o, "R7", "pins at done",
              {mdc_o, mdio_oe_o}, 128'd0);
          tl = e.wr ? "R12" : (e.resp ? "R5" : "R6");
          chk(rdata_o == e.rd, tl, "read data", rdata_o, e.rd);
          chk(nack_o == e.nack, tl, "nack flag", nack_o, e.nack);
        end
        cap = '0; n_oe = 0; n_rise = 0; per_bad = 0;
      end
    end
  end

  task automatic run_txn(input bit wr, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit resp,
                         input logic [15:0] pd, input bit extra_start);
    exp_t e;
    e.wr   = wr;
    e.resp = resp;
    if (wr) begin
      e.bits = {63'd0, 32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, wd, 1'b1};
      e.len  = 65;
      e.nack = 1'b0;
    end else begin
      e.bits = {81'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra, 1'b0};
      e.len  = 47;
      e.nack = !resp;
      last_rd = resp ? pd : 16'h0000;
    end
    e.rd = last_rd;
    sb_q.push_back(e);
    cur_rd   = !wr;
    phy_resp = resp;
    phy_data = pd;
    @(negedge clk);
    write_i = wr; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10", "busy after start", busy_o, 1'b1);
    if (extra_start) begin
      repeat (50) @(negedge clk);
      write_i = !wr; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    do @(negedge clk); while (busy_o);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; write_i = 1'b0; phy_addr_i = '0;
    reg_addr_i = '0; wdata_i = '0; mdio_i = 1'b1; cur_rd = 1'b0;
    phy_resp = 1'b0; phy_data = '0; last_rd = '0; cap = '0;
    n_oe = 0; n_rise = 0; per_bad = 0; last_rise = 0; cyc = 0; prev_dout = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(mdc_o == 1'b0, "R11", "mdc after reset", mdc_o, 0);
    chk(mdio_oe_o == 1'b0, "R11", "oe after reset", mdio_oe_o, 0);
    chk(busy_o == 1'b0, "R11", "busy after reset", busy_o, 0);
    chk(done_o == 1'b0, "R11", "done after reset", done_o, 0);
    chk(rdata_o == 16'h0, "R11", "rdata after reset", rdata_o, 0);
    chk(nack_o == 1'b0, "R11", "nack after reset", nack_o, 0);

    run_txn(1'b1, 5'h01, 5'h00, 16'hA5C3, 1'b0, 16'h0000, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h1F, 16'h0000, 1'b1, 16'h8001, 1'b0);
    // R12: write must keep 16'h8001
    run_txn(1'b1, 5'h0A, 5'h15, 16'h0000, 1'b0, 16'h0000, 1'b0);
    // R6: no acknowledge while the model still drives a pattern
    run_txn(1'b0, 5'h03, 5'h11, 16'h0000, 1'b0, 16'hFFFF, 1'b0);
    // R10: extra start during the frame is ignored
    run_txn(1'b0, 5'h12, 5'h0D, 16'h0000, 1'b1, 16'h5A3C, 1'b1);

    repeat (20) @(negedge clk);
    chk(n_done == 5, "R10", "done pulse count", 128'(n_done), 128'd5);
    chk(sb_q.size() == 0, "R10", "pending frames", 128'(sb_q.size()), 128'd0);
    chk(r8_bad == 0, "R8", "data change with clock high", 128'(r8_bad), 128'd0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule